// File: doc/BRIEF.md
# Interrupt Enable/Status Register with Pin Driver

This block holds the interrupt state of a line-side transceiver in one 16-bit register word. The upper byte holds one enable bit per interrupt source and the lower byte holds one sticky status bit per source. Single-cycle event pulses from the surrounding logic set the status bits. Reading the word returns both bytes and clears every status bit in the same step. Software therefore sees each condition once, and it never needs a second access to acknowledge it.

One interrupt line leaves the block. The line is active while any status bit is set together with its enable bit. A polarity bit selects the line's behaviour. In the default active-low setting the line acts as an open-drain output: the pad is enabled only to pull low, and it is released otherwise. In the active-high setting the pad is always driven and carries the level.

Top module: `irq_csr`

## Requirements
- R1: After reset the enable byte and the status byte are zero, the polarity is active-low, and the line is released (`irq_oe` = 0, `irq_level` = 0).
- R2: A pulse on `evt_pulse[i]` sets status bit i (read data bit i) from the next clock edge, whether or not enable bit i is set.
- R3: A status bit stays set across cycles that have no read strobe.
- R4: While `rd_stb` is high, `rd_data` shows {enable byte, status byte} as held before the clear. After that edge every status bit is zero, unless R5 applies.
- R5: An event pulse in the same cycle as a read strobe leaves its status bit set after the clear.
- R6: A write strobe `en_wr` loads `en_wdata` into the enable byte (read data bits [15:8]) from the next edge, and it does not change the status byte.
- R7: The interrupt is active exactly when the bitwise AND of the enable byte and the status byte is nonzero.
- R8: With active-low polarity (`pol_wdata` value 0), `irq_level` is 0 and `irq_oe` equals the active condition. With active-high polarity (value 1), `irq_oe` is 1 and `irq_level` equals the active condition.
- R9: A strobe on `pol_wr` loads `pol_wdata` into the polarity bit from the next edge.
- R10: The interrupt goes inactive in the cycle that follows the read which clears the last enabled status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 8 | One-cycle event pulses, one per source |
| en_wr | input | 1 | Write strobe for the enable byte |
| en_wdata | input | 8 | New enable byte |
| pol_wr | input | 1 | Write strobe for the polarity bit |
| pol_wdata | input | 1 | Polarity: 0 active-low open-drain, 1 active-high |
| rd_stb | input | 1 | Read strobe; clears the status byte at the edge |
| rd_data | output | 16 | {enable byte, status byte} |
| irq_level | output | 1 | Level presented to the interrupt pad |
| irq_oe | output | 1 | Pad output enable |

## Verification
Events are applied with all enables clear, to show that status records them while the line stays quiet. Events are also applied on several sources in separate cycles, to show that bits accumulate and do not overwrite each other. A read is issued in the same cycle as a fresh event, which separates a design that loses the event from one that keeps it. The same sequences are repeated under both polarities. In each polarity the bench checks whether the line is released or pulled, and whether the line drops exactly one edge after the clearing read.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    localparam int unsigned SRC_COUNT = 8;

    typedef enum logic {
        POL_ACT_LOW  = 1'b0,
        POL_ACT_HIGH = 1'b1
    } irq_pol_e;

    typedef struct packed {
        logic level;
        logic oe;
    } pad_drive_t;

    function automatic pad_drive_t pad_for(irq_pol_e pol, logic active);
        pad_drive_t d;
        if (pol == POL_ACT_HIGH) begin
            d.level = active;
            d.oe    = 1'b1;
        end else begin
            d.level = 1'b0;
            d.oe    = active;
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_all,
    output logic [N-1:0] status
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status[g] <= 1'b0;
            end else begin
                // a new pulse wins over the read clear
                status[g] <= set_pulse[g] | (status[g] & ~clr_all);
            end
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] enable
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (wr) begin
            enable <= wdata;
        end
    end
endmodule

// File: rtl/irq_pad_drv.sv
module irq_pad_drv
    import irq_csr_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] enable,
    input  logic [N-1:0] status,
    input  irq_pol_e     pol,
    output logic         level,
    output logic         oe
);
    logic       active;
    pad_drive_t drv;

    always_comb begin
        active = |(enable & status);
        drv    = pad_for(pol, active);
        level  = drv.level;
        oe     = drv.oe;
    end
endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_csr_pkg::*;
#(
    parameter int unsigned N = SRC_COUNT,
    localparam int unsigned W = 2 * N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_pulse,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic         pol_wr,
    input  logic         pol_wdata,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    output logic         irq_level,
    output logic         irq_oe
);
    logic [N-1:0] en_q;
    logic [N-1:0] st_q;
    irq_pol_e     pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= POL_ACT_LOW;
        end else if (pol_wr) begin
            pol_q <= irq_pol_e'(pol_wdata);
        end
    end

    irq_enable_reg #(.N(N)) u_en (
        .clk    (clk),
        .rst    (rst),
        .wr     (en_wr),
        .wdata  (en_wdata),
        .enable (en_q)
    );

    irq_status_bank #(.N(N)) u_st (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_pulse),
        .clr_all   (rd_stb),
        .status    (st_q)
    );

    irq_pad_drv #(.N(N)) u_pad (
        .enable (en_q),
        .status (st_q),
        .pol    (pol_q),
        .level  (irq_level),
        .oe     (irq_oe)
    );

    assign rd_data = {en_q, st_q};
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk #(
    parameter int unsigned N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   evt_pulse,
    input logic           en_wr,
    input logic [N-1:0]   en_wdata,
    input logic           rd_stb,
    input logic [2*N-1:0] rd_data,
    input logic           pol_q,
    input logic           irq_level,
    input logic           irq_oe
);
    logic act;
    assign act = |(rd_data[2*N-1:N] & rd_data[N-1:0]);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !irq_oe && !irq_level));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse) |=> ((rd_data[N-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((rd_data[N-1:0] & $past(rd_data[N-1:0])) == $past(rd_data[N-1:0])));

    // R4 and R5: after a read only the same-cycle events remain
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_data[N-1:0] == $past(evt_pulse)));

    a_r6_enable_write: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (rd_data[2*N-1:N] == $past(en_wdata)));

    a_r8_open_drain: assert property (@(posedge clk) disable iff (rst)
        !pol_q |-> (!irq_level && (irq_oe == act)));

    a_r8_push_pull: assert property (@(posedge clk) disable iff (rst)
        pol_q |-> (irq_oe && (irq_level == act)));
endmodule

bind irq_csr irq_csr_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .pol_q     (pol_q),
    .irq_level (irq_level),
    .irq_oe    (irq_oe)
);

// File: tb/irq_csr_test.sv
module irq_csr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_pulse = '0;
    logic        en_wr = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic        pol_wr = 1'b0;
    logic        pol_wdata = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic        irq_level;
    logic        irq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_en  = '0;
    logic [7:0] m_st  = '0;
    logic       m_pol = 1'b0;

    logic [15:0] sb_data[$];
    string       sb_tag[$];

    always #2.5 clk = ~clk;

    irq_csr uut (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .pol_wr    (pol_wr),
        .pol_wdata (pol_wdata),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .irq_level (irq_level),
        .irq_oe    (irq_oe)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (rd_stb && !rst) begin
            if (sb_data.size() == 0) begin
                check("R4 scoreboard empty", 16'h1, 16'h0);
            end else begin
                check(sb_tag.pop_front(), rd_data, sb_data.pop_front());
            end
        end
    end

    // pad check against the model; the tag names the requirement
    task automatic check_pad(string tag);
        logic act;
        logic [1:0] exp;
        act = |(m_en & m_st);
        exp = m_pol ? {act, 1'b1} : {1'b0, act};
        check(tag, {14'd0, irq_level, irq_oe}, {14'd0, exp});
    endtask

    task automatic step(input logic [7:0] evt, input logic rd,
                        input logic wen, input logic [7:0] wd,
                        input logic pw, input logic pd,
                        input string pad_tag, input string rd_tag);
        @(negedge clk);
        #1;
        check_pad(pad_tag);
        evt_pulse = evt;
        rd_stb    = rd;
        en_wr     = wen;
        en_wdata  = wd;
        pol_wr    = pw;
        pol_wdata = pd;
        if (rd) begin
            sb_data.push_back({m_en, m_st});
            sb_tag.push_back(rd_tag);
        end
        @(posedge clk);
        m_st = (rd ? 8'h00 : m_st) | evt;
        if (wen) m_en = wd;
        if (pw) m_pol = pd;
    endtask

    task automatic idle(string tag);
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset read data", rd_data, 16'h0000);
        check_pad("R1 reset pad released");
        // R2: events with all enables clear; line stays quiet (R7)
        step(8'h05, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R1 pad idle", "");
        idle("R7 disabled status does not assert");
        idle("R3 hold");
        step(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3 hold2", "R2 status set without enable");
        idle("R4 cleared after read");
        check("R4 status cleared", rd_data, 16'h0000);
        // R6: enable write does not touch status
        step(8'h04, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R7 idle", "");
        step(8'h00, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0, "R7 not yet enabled", "");
        idle("R8 open-drain pulls low when active");
        check("R6 enable loaded, status kept", rd_data, 16'h0404);
        // R10: read clears the last enabled bit
        step(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R8 still active", "R4 read returns pre-clear value");
        idle("R10 released one edge after read");
        // R5: event in the same cycle as a read
        step(8'h02, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R10 idle", "");
        step(8'h80, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7 unenabled bit quiet", "R4 read before collision");
        step(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R5 pad", "R5 same-cycle event kept");
        // R9: active-high polarity
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9 before polarity write", "");
        idle("R9 push-pull inactive drives low");
        step(8'h01, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R9 idle", "");
        step(8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R8 active-high asserted", "");
        idle("R3 accumulate");
        step(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R8 hold", "R3 bits accumulate");
        idle("R10 active-high deasserts");
        // back to active-low
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R10 idle", "");
        step(8'h40, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 back to open-drain released", "");
        idle("R8 open-drain active again");
        idle("R8 open-drain end");
        finish_run();
    end
endmodule